// File: doc/BRIEF.md
# Switched Shared SRAM Window

This block places one external static RAM between two processor buses. The host bus reaches the RAM through a small window. The window offset gives the low address bits, and a page number held elsewhere gives the high bits. The console bus has no read/write line, so the whole RAM appears to it as a flat read-only cartridge image. An ownership input selects which bus drives the RAM address, data and strobes. The bus that does not own the RAM reads all-ones.

The owner input comes from a control register outside this block. The block registers that input, and the registered owner changes only on a clock edge where the current owner's bus is idle. An access that is already running is therefore never cut off. A small range at the top of the console address space is kept for mailbox ports that sit outside this block. In that range the RAM chip select stays low.

Read data from the RAM is taken combinationally, and both read-data outputs are registered. Each read result is therefore valid one clock after the cycle that carries the read strobe.

Top module: `shared_sram_window`

## Requirements
- R1: While the host owns the RAM and a host access is active, `ram_addr` equals `{page, host_addr}`, with the page as the upper bits.
- R2: `ram_we` is high only in a cycle where the host owns the RAM, `host_sel` is high and `host_wr` is high. In such a cycle the byte on `host_wdata` is written at the R1 address.
- R3: While the host owns the RAM, a host read (`host_sel` and `host_rd` high, `host_wr` low) puts the RAM byte at the R1 address on `host_rdata` one clock later. `host_rdata` keeps that value until the next host read.
- R4: While the console owns the RAM, a host read returns 0xFF and a host write leaves the RAM contents unchanged.
- R5: While the console owns the RAM, a console read (`con_sel` high, `con_addr` below MBOX_BASE) puts the RAM byte at `con_addr` on `con_rdata` one clock later, with `con_drive` high.
- R6: While the host owns the RAM, a console read returns 0xFF with `con_drive` low.
- R7: Console addresses at or above MBOX_BASE keep `ram_cs` low and return 0xFF with `con_drive` low. The default MBOX_BASE is 0xFF8, which covers the top eight addresses.
- R8: No console access ever writes the RAM.
- R9: The registered owner follows `owner_con` (1 = console, 0 = host) only on an edge where the current owner's bus is idle. For the host, idle means no `host_sel` together with a read or write strobe. For the console, idle means `con_sel` low.
- R10: After reset the host owns the RAM, both read-data outputs are 0xFF and `con_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owner_con | input | 1 | Requested owner: 1 console, 0 host |
| page | input | 4 | Upper RAM address bits for the host window |
| host_sel | input | 1 | Host window select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Offset inside the host window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| con_sel | input | 1 | Console cartridge-space select |
| con_addr | input | 12 | Console address |
| con_rdata | output | 8 | Console read data, registered |
| con_drive | output | 1 | Console data bus drive enable |
| ram_cs | output | 1 | RAM chip select |
| ram_oe | output | 1 | RAM output enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 12 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
A wrong registered owner shows up one clock later in one of two ways. Either the bus that should be shut out gets real RAM bytes, or the bus that owns the RAM gets 0xFF. If the owner switches in the middle of an access, the data returned in that same access is wrong. A wrong page or window offset in the address leaves no mark on the cycle that writes. It only becomes visible when a later full read-back of every address finds a byte in the wrong place. For that reason the bench writes a distinct pattern to every address and then reads all of them back from both buses.

// File: rtl/swin_pkg.sv
package swin_pkg;
    typedef enum logic {
        OWN_HOST = 1'b0,
        OWN_CON  = 1'b1
    } owner_e;
endpackage

// File: rtl/swin_owner.sv
module swin_owner
    import swin_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   owner_con,
    input  logic   host_busy,
    input  logic   con_busy,
    output owner_e owner_q
);
    typedef struct packed {
        owner_e owner;
    } own_state_t;

    own_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // switch only while the current owner's bus is quiet
        if (st_q.owner == OWN_HOST) begin
            if (!host_busy) st_d.owner = owner_con ? OWN_CON : OWN_HOST;
        end else begin
            if (!con_busy) st_d.owner = owner_con ? OWN_CON : OWN_HOST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{owner: OWN_HOST};
        else        st_q <= st_d;
    end

    assign owner_q = st_q.owner;
endmodule

// File: rtl/swin_route.sv
module swin_route
    import swin_pkg::*;
#(
    parameter int unsigned LO_W      = 8,
    parameter int unsigned PAGE_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MBOX_BASE = 4088,
    localparam int unsigned ADDR_W   = LO_W + PAGE_W
) (
    input  owner_e              owner,
    input  logic [PAGE_W-1:0]   page,
    input  logic                host_sel,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [LO_W-1:0]     host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                con_sel,
    input  logic [ADDR_W-1:0]   con_addr,
    output logic                con_hit,
    output logic                ram_cs,
    output logic                ram_oe,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata
);
    logic host_act;

    always_comb begin
        host_act = host_sel && (host_rd || host_wr);
        con_hit  = con_sel && (con_addr < ADDR_W'(MBOX_BASE));
        if (owner == OWN_HOST) begin
            ram_addr  = {page, host_addr};
            ram_cs    = host_act;
            ram_we    = host_sel && host_wr;
            ram_oe    = host_sel && host_rd && !host_wr;
            ram_wdata = host_wdata;
        end else begin
            ram_addr  = con_addr;
            ram_cs    = con_hit;
            ram_we    = 1'b0;
            ram_oe    = con_hit;
            ram_wdata = '0;
        end
    end
endmodule

// File: rtl/swin_ret.sv
module swin_ret
    import swin_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  owner_e            owner,
    input  logic              host_read,
    input  logic              con_sel,
    input  logic              con_hit,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] con_rdata,
    output logic              con_drive
);
    typedef struct packed {
        logic [DATA_W-1:0] host_data;
        logic [DATA_W-1:0] con_data;
        logic              drive;
    } ret_state_t;

    ret_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_read)
            st_d.host_data = (owner == OWN_HOST) ? ram_rdata : '1;
        st_d.drive    = con_sel && con_hit && (owner == OWN_CON);
        st_d.con_data = st_d.drive ? ram_rdata : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{host_data: '1, con_data: '1, drive: 1'b0};
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.host_data;
    assign con_rdata  = st_q.con_data;
    assign con_drive  = st_q.drive;
endmodule

// File: rtl/shared_sram_window.sv
module shared_sram_window
    import swin_pkg::*;
#(
    parameter int unsigned LO_W      = 8,
    parameter int unsigned PAGE_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MBOX_BASE = 4088,
    localparam int unsigned ADDR_W   = LO_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              owner_con,
    input  logic [PAGE_W-1:0] page,
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [LO_W-1:0]   host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              con_sel,
    input  logic [ADDR_W-1:0] con_addr,
    output logic [DATA_W-1:0] con_rdata,
    output logic              con_drive,
    output logic              ram_cs,
    output logic              ram_oe,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    owner_e own_q;
    logic   con_hit;
    logic   host_busy;
    logic   host_read;

    assign host_busy = host_sel && (host_rd || host_wr);
    assign host_read = host_sel && host_rd && !host_wr;

    swin_owner u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner_con (owner_con),
        .host_busy (host_busy),
        .con_busy  (con_sel),
        .owner_q   (own_q)
    );

    swin_route #(
        .LO_W(LO_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .MBOX_BASE(MBOX_BASE)
    ) u_route (
        .owner      (own_q),
        .page       (page),
        .host_sel   (host_sel),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .con_sel    (con_sel),
        .con_addr   (con_addr),
        .con_hit    (con_hit),
        .ram_cs     (ram_cs),
        .ram_oe     (ram_oe),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );

    swin_ret #(.DATA_W(DATA_W)) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .owner      (own_q),
        .host_read  (host_read),
        .con_sel    (con_sel),
        .con_hit    (con_hit),
        .ram_rdata  (ram_rdata),
        .host_rdata (host_rdata),
        .con_rdata  (con_rdata),
        .con_drive  (con_drive)
    );
endmodule

// File: rtl/swin_checker.sv
module swin_checker #(
    parameter int unsigned LO_W      = 8,
    parameter int unsigned PAGE_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MBOX_BASE = 4088,
    localparam int unsigned ADDR_W   = LO_W + PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              own_q,
    input logic [PAGE_W-1:0] page,
    input logic              host_sel,
    input logic              host_rd,
    input logic              host_wr,
    input logic [LO_W-1:0]   host_addr,
    input logic              con_sel,
    input logic [ADDR_W-1:0] con_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic [DATA_W-1:0] con_rdata,
    input logic              con_drive,
    input logic              ram_cs,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr
);
    AST_HOST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_q && host_sel && (host_rd || host_wr)) |-> (ram_addr == {page, host_addr})); // R1
    AST_WE_HOST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (!own_q && host_sel && host_wr)); // R2
    AST_HOST_SHUT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q && host_sel && host_rd && !host_wr) |=> (host_rdata == '1)); // R4
    AST_CON_SHUT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_q && con_sel) |=> (con_rdata == '1 && !con_drive)); // R6
    AST_MBOX_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q && con_sel && con_addr >= ADDR_W'(MBOX_BASE)) |-> !ram_cs); // R7
    AST_CON_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        own_q |-> !ram_we); // R8
    AST_OWNER_SWITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(own_q) |-> ($past(own_q) ? !$past(con_sel)
                                          : !$past(host_sel && (host_rd || host_wr)))); // R9
endmodule

bind shared_sram_window swin_checker #(
    .LO_W(LO_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .MBOX_BASE(MBOX_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .own_q      (own_q),
    .page       (page),
    .host_sel   (host_sel),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .con_sel    (con_sel),
    .con_addr   (con_addr),
    .host_rdata (host_rdata),
    .con_rdata  (con_rdata),
    .con_drive  (con_drive),
    .ram_cs     (ram_cs),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr)
);

// File: tb/test_shared_sram_window.sv
module test_shared_sram_window;
    localparam int LO_W = 8;
    localparam int PAGE_W = 2;
    localparam int DATA_W = 8;
    localparam int AW = LO_W + PAGE_W;
    localparam int DEPTH = 1 << AW;
    localparam int MBOX = DEPTH - 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic owner_con = 1'b0;
    logic [PAGE_W-1:0] page = '0;
    logic host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [LO_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata, con_rdata, ram_wdata, ram_rdata;
    logic con_sel = 1'b0;
    logic [AW-1:0] con_addr = '0;
    logic con_drive, ram_cs, ram_oe, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DATA_W-1:0] mem [DEPTH];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shared_sram_window #(.LO_W(LO_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .MBOX_BASE(MBOX)) i_shared_sram_window (
        .clk(clk), .rst_n(rst_n), .owner_con(owner_con), .page(page),
        .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .con_sel(con_sel), .con_addr(con_addr), .con_rdata(con_rdata),
        .con_drive(con_drive), .ram_cs(ram_cs), .ram_oe(ram_oe), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // asynchronous-read, clocked-write SRAM model
    always @(posedge clk) if (ram_cs && ram_we) mem[ram_addr] <= ram_wdata;
    assign ram_rdata = mem[ram_addr];

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29 + (a >> 5)) ^ 8'h5A);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(int a, logic [7:0] d);
        @(negedge clk);
        page = PAGE_W'(a >> LO_W); host_addr = LO_W'(a); host_wdata = d;
        host_sel = 1'b1; host_wr = 1'b1;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(int a, output logic [7:0] d);
        @(negedge clk);
        page = PAGE_W'(a >> LO_W); host_addr = LO_W'(a);
        host_sel = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        d = host_rdata;
        host_sel = 1'b0; host_rd = 1'b0;
    endtask

    task automatic con_read(int a, output logic [7:0] d, output logic drv);
        @(negedge clk);
        con_addr = AW'(a); con_sel = 1'b1;
        @(negedge clk);
        d = con_rdata; drv = con_drive;
        con_sel = 1'b0;
    endtask

    task automatic set_owner(logic c);
        @(negedge clk);
        owner_con = c;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        logic drv;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 host_rdata", host_rdata, 8'hFF);
        check("R10 con_rdata", con_rdata, 8'hFF);
        check("R10 con_drive", con_drive, 0);

        // R1 R2: host writes across every page and offset
        for (int a = 0; a < DEPTH; a++) host_write(a, pat(a));
        for (int a = 0; a < DEPTH; a++) check("R1 R2 mem image", mem[a], pat(a));
        // R3: host read-back
        for (int a = 0; a < DEPTH; a++) begin
            host_read(a, d);
            check("R3 host read", d, pat(a));
        end
        // R6: console shut out while host owns
        for (int a = 0; a < DEPTH; a += 37) begin
            con_read(a, d, drv);
            check("R6 con data", d, 8'hFF);
            check("R6 con drive", drv, 0);
        end

        set_owner(1'b1);
        // R5 R7: console sweep
        for (int a = 0; a < DEPTH; a++) begin
            con_read(a, d, drv);
            if (a < MBOX) begin
                check("R5 con data", d, pat(a));
                check("R5 con drive", drv, 1);
            end else begin
                check("R7 mbox data", d, 8'hFF);
                check("R7 mbox drive", drv, 0);
            end
        end
        // R4: host shut out, writes ignored
        for (int a = 0; a < DEPTH; a += 17) begin
            host_read(a, d);
            check("R4 host read", d, 8'hFF);
            host_write(a, ~pat(a));
        end
        for (int a = 0; a < DEPTH; a += 17) check("R4 R8 mem kept", mem[a], pat(a));

        // R9: owner change waits for console to go idle
        @(negedge clk);
        con_addr = AW'(5); con_sel = 1'b1;
        @(negedge clk);
        owner_con = 1'b0;
        @(negedge clk);
        check("R9 con still owner data", con_rdata, pat(5));
        check("R9 con still owner drive", con_drive, 1);
        host_read(9, d);
        check("R9 host still shut out", d, 8'hFF);
        @(negedge clk);
        con_sel = 1'b0;
        @(negedge clk);
        host_read(9, d);
        check("R9 host owns after idle", d, pat(9));

        // R9: change to console waits for host to go idle
        @(negedge clk);
        page = '0; host_addr = 8'd3; host_sel = 1'b1; host_rd = 1'b1;
        owner_con = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 host keeps owner", host_rdata, pat(3));
        host_sel = 1'b0; host_rd = 1'b0;
        @(negedge clk);
        con_read(3, d, drv);
        check("R9 console owns after idle", d, pat(3));
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule